// File: doc/BRIEF.md
# DDR3 Reset and Initialization Sequencer

This block sits on the controller side of a DDR3 interface. It brings the memory device out of reset and into normal operation. It drives the device reset pin (active low) and the clock-enable pin. It then issues the mode-register writes and a long ZQ calibration, and finally raises a flag that tells the rest of the controller that traffic may begin. Every interval is a parameter counted in controller clock cycles. Intervals that the device defines as "the larger of two values" are folded into one cycle count when the design elaborates.

There are two ways in. A synchronous controller reset starts the cold power-up path, which has the long reset-hold time. A warm-reset request, accepted in any state, starts the shorter path used when power stays stable. After the reset pin is released, both paths go through the same steps. The four mode-register values come in on input ports. Each value is sampled on the clock edge that issues its write command.

Command pins are registered. A command lasts exactly one cycle, and every other cycle carries a NOP. The bank-address bits select which mode register is written.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst` is high, after each clock edge: `dram_rst_n`=0, `dram_cke`=0, `init_done`=0, command pins {cs_n,ras_n,cas_n,we_n}=4'b0111 (NOP), `dram_ba`=0 and `dram_addr`=0.
- R2: After the last clock edge that samples `rst` high, `dram_rst_n` stays low for exactly T_RST_COLD cycles and then rises.
- R3: A `warm_req` sampled high in any state drives `dram_rst_n`, `dram_cke` and `init_done` low after that edge. After the last edge that samples `warm_req` high, `dram_rst_n` stays low for exactly max(T_RST_WARM, T_CKE_PRE) cycles. This keeps CKE low for at least T_CKE_PRE cycles before reset is released.
- R4: `dram_cke` rises exactly max(T_CKE_WAIT, max(T_CLK_10NS, 5)) cycles after `dram_rst_n` rises.
- R5: The first mode-register write is issued exactly max(T_XS, 5) cycles after `dram_cke` rises.
- R6: There are exactly four mode-register writes, with pins 4'b0000 and `dram_ba` = 2, 3, 1, 0 in that order. Each carries on `dram_addr` the value of `mr2`, `mr3`, `mr1` and `mr0` respectively.
- R7: Consecutive mode-register writes are exactly T_MRD cycles apart.
- R8: The long ZQ calibration (pins 4'b0110, `dram_addr` bit 10 set, all other address bits 0, `dram_ba`=0) is issued exactly T_MOD cycles after the last mode-register write.
- R9: Every command lasts one cycle. Every cycle that carries neither a mode-register write nor the calibration command carries NOP (4'b0111). Exactly one calibration command is issued per sequence.
- R10: `init_done` rises exactly max(T_DLLK, T_ZQINIT) cycles after the calibration command. It then stays high, with only NOPs issued, until `rst` or `warm_req`.
- R11: A command other than NOP is driven only while `dram_cke` is high and `dram_rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset; starts the cold path |
| warm_req | input | 1 | Synchronous warm-reset request; starts the short path |
| mr0 | input | ADDR_W | Value written to mode register 0 |
| mr1 | input | ADDR_W | Value written to mode register 1 |
| mr2 | input | ADDR_W | Value written to mode register 2 |
| mr3 | input | ADDR_W | Value written to mode register 3 |
| dram_rst_n | output | 1 | Device reset, active low |
| dram_cke | output | 1 | Device clock enable |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_ba | output | BA_W | Bank address (selects the mode register) |
| dram_addr | output | ADDR_W | Address bus (mode value or calibration flag) |
| init_done | output | 1 | Initialization complete |

## Verification
The checker assumes that `rst` and `warm_req` are synchronous to `clk`, and it clears its own counters of mode-register writes, write spacing and calibration whenever either input is sampled high. The bench therefore changes both inputs two nanoseconds after a rising edge and holds each one for whole cycles. The mode values are assumed stable from the first write to the calibration command. The bench sets them before each run and leaves them alone until the next run. It sweeps the warm request across every cycle offset of a complete sequence, including the offsets after `init_done`, so that every state is interrupted at least once.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  typedef enum logic [2:0] {
    ST_RST,
    ST_CKEL,
    ST_XPR,
    ST_MRS,
    ST_ZQ,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_MRS,
    CMD_ZQCL
  } seq_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Write slot (0..3) to mode register number: 2, 3, 1, 0
  function automatic logic [1:0] mr_of_slot(input logic [1:0] slot);
    case (slot)
      2'd0:    return 2'd2;
      2'd1:    return 2'd3;
      2'd2:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - CNT_W'(1);
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/ddr3_mr_pick.sv
module ddr3_mr_pick
  import ddr3_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned BA_W   = 3
) (
  input  logic [1:0]        slot,
  input  logic [ADDR_W-1:0] mr0,
  input  logic [ADDR_W-1:0] mr1,
  input  logic [ADDR_W-1:0] mr2,
  input  logic [ADDR_W-1:0] mr3,
  output logic [BA_W-1:0]   sel_ba,
  output logic [ADDR_W-1:0] sel_val
);

  logic [1:0] reg_no;

  always_comb begin
    reg_no = mr_of_slot(slot);
    sel_ba = BA_W'(reg_no);
    case (reg_no)
      2'd0:    sel_val = mr0;
      2'd1:    sel_val = mr1;
      2'd2:    sel_val = mr2;
      default: sel_val = mr3;
    endcase
  end

endmodule

// File: rtl/ddr3_cmd_enc.sv
module ddr3_cmd_enc
  import ddr3_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned BA_W   = 3
) (
  input  seq_cmd_e          cmd,
  input  logic [BA_W-1:0]   mrs_ba,
  input  logic [ADDR_W-1:0] mrs_val,
  output cmd_pins_t         pins,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int unsigned ZQ_LONG_BIT = 10;

  always_comb begin
    pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    ba   = '0;
    addr = '0;
    case (cmd)
      CMD_MRS: begin
        pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
        ba   = mrs_ba;
        addr = mrs_val;
      end
      CMD_ZQCL: begin
        pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};
        addr[ZQ_LONG_BIT] = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int unsigned T_RST_COLD = 80000,
  parameter int unsigned T_RST_WARM = 40,
  parameter int unsigned T_CKE_PRE  = 4,
  parameter int unsigned T_CKE_WAIT = 200000,
  parameter int unsigned T_CLK_10NS = 4,
  parameter int unsigned T_XS       = 108,
  parameter int unsigned T_MRD      = 4,
  parameter int unsigned T_MOD      = 12,
  parameter int unsigned T_DLLK     = 512,
  parameter int unsigned T_ZQINIT   = 512,
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned BA_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_req,
  input  logic [ADDR_W-1:0] mr0,
  input  logic [ADDR_W-1:0] mr1,
  input  logic [ADDR_W-1:0] mr2,
  input  logic [ADDR_W-1:0] mr3,
  output logic              dram_rst_n,
  output logic              dram_cke,
  output logic              dram_cs_n,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [BA_W-1:0]   dram_ba,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              init_done
);

  // Folded intervals, all in controller cycles
  localparam int unsigned RST_WARM_CYC = imax(T_RST_WARM, T_CKE_PRE);
  localparam int unsigned CLK_STB_CYC  = imax(T_CLK_10NS, 5);
  localparam int unsigned CKEL_CYC     = imax(T_CKE_WAIT, CLK_STB_CYC);
  localparam int unsigned XPR_CYC      = imax(T_XS, 5);
  localparam int unsigned ZQW_CYC      = imax(T_DLLK, T_ZQINIT);
  localparam int unsigned MAX_CYC      = imax(imax(imax(T_RST_COLD, RST_WARM_CYC), imax(CKEL_CYC, XPR_CYC)),
                                              imax(imax(T_MRD, T_MOD), ZQW_CYC));
  localparam int unsigned CNT_W        = $clog2(MAX_CYC + 1);

  seq_state_e        st_q, st_n;
  logic [1:0]        slot_q, slot_n;
  logic              rstn_q, rstn_n;
  logic              cke_q, cke_n;
  logic              done_q, done_n;
  seq_cmd_e          cmd_n;
  logic              ld;
  logic [CNT_W-1:0]  ld_val;
  logic              tmr_zero;

  logic [BA_W-1:0]   pick_ba;
  logic [ADDR_W-1:0] pick_val;
  cmd_pins_t         pins_n;
  logic [BA_W-1:0]   ba_n;
  logic [ADDR_W-1:0] addr_n;

  ddr3_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .load     (ld),
    .load_val (ld_val),
    .zero     (tmr_zero)
  );

  ddr3_mr_pick #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_pick (
    .slot    (slot_n),
    .mr0     (mr0),
    .mr1     (mr1),
    .mr2     (mr2),
    .mr3     (mr3),
    .sel_ba  (pick_ba),
    .sel_val (pick_val)
  );

  ddr3_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
    .cmd     (cmd_n),
    .mrs_ba  (pick_ba),
    .mrs_val (pick_val),
    .pins    (pins_n),
    .ba      (ba_n),
    .addr    (addr_n)
  );

  always_comb begin
    st_n   = st_q;
    slot_n = slot_q;
    rstn_n = rstn_q;
    cke_n  = cke_q;
    done_n = done_q;
    cmd_n  = CMD_NOP;
    ld     = 1'b0;
    ld_val = '0;
    if (rst || warm_req) begin
      st_n   = ST_RST;
      slot_n = 2'd0;
      rstn_n = 1'b0;
      cke_n  = 1'b0;
      done_n = 1'b0;
      ld     = 1'b1;
      ld_val = rst ? CNT_W'(T_RST_COLD - 1) : CNT_W'(RST_WARM_CYC - 1);
    end else if (tmr_zero) begin
      case (st_q)
        ST_RST: begin
          st_n   = ST_CKEL;
          rstn_n = 1'b1;
          ld     = 1'b1;
          ld_val = CNT_W'(CKEL_CYC - 1);
        end
        ST_CKEL: begin
          st_n   = ST_XPR;
          cke_n  = 1'b1;
          ld     = 1'b1;
          ld_val = CNT_W'(XPR_CYC - 1);
        end
        ST_XPR: begin
          st_n   = ST_MRS;
          slot_n = 2'd0;
          cmd_n  = CMD_MRS;
          ld     = 1'b1;
          ld_val = CNT_W'(T_MRD - 1);
        end
        ST_MRS: begin
          ld = 1'b1;
          if (slot_q == 2'd3) begin
            st_n   = ST_ZQ;
            cmd_n  = CMD_ZQCL;
            ld_val = CNT_W'(ZQW_CYC - 1);
          end else begin
            slot_n = slot_q + 2'd1;
            cmd_n  = CMD_MRS;
            // the last write is followed by the mode-update wait
            ld_val = (slot_n == 2'd3) ? CNT_W'(T_MOD - 1) : CNT_W'(T_MRD - 1);
          end
        end
        ST_ZQ: begin
          st_n   = ST_DONE;
          done_n = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    st_q       <= st_n;
    slot_q     <= slot_n;
    rstn_q     <= rstn_n;
    cke_q      <= cke_n;
    done_q     <= done_n;
    dram_cs_n  <= pins_n.cs_n;
    dram_ras_n <= pins_n.ras_n;
    dram_cas_n <= pins_n.cas_n;
    dram_we_n  <= pins_n.we_n;
    dram_ba    <= ba_n;
    dram_addr  <= addr_n;
  end

  assign dram_rst_n = rstn_q;
  assign dram_cke   = cke_q;
  assign init_done  = done_q;

endmodule

// File: rtl/ddr3_init_seq_chk.sv
module ddr3_init_seq_chk #(
  parameter int unsigned BA_W = 3,
  parameter int unsigned MRD  = 4,
  parameter int unsigned CKEL = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            warm_req,
  input logic            dram_rst_n,
  input logic            dram_cke,
  input logic            dram_cs_n,
  input logic            dram_ras_n,
  input logic            dram_cas_n,
  input logic            dram_we_n,
  input logic [BA_W-1:0] dram_ba,
  input logic            init_done
);

  localparam int unsigned GAP_W = $clog2(MRD + 1) + 1;
  localparam int unsigned LOW_W = $clog2(CKEL + 1) + 1;

  logic [3:0] pins;
  logic       is_nop, is_mrs, is_zq;
  assign pins   = {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n};
  assign is_nop = (pins == 4'b0111);
  assign is_mrs = (pins == 4'b0000);
  assign is_zq  = (pins == 4'b0110);

  logic [GAP_W-1:0] gap_cnt;
  logic [LOW_W-1:0] low_cnt;
  logic [2:0]       mrs_seen;
  logic             zq_seen;
  logic [BA_W-1:0]  exp_ba;

  always_ff @(posedge clk) begin
    if (rst || warm_req) begin
      gap_cnt  <= GAP_W'(MRD);
      mrs_seen <= '0;
      zq_seen  <= 1'b0;
    end else begin
      if (is_mrs) begin
        gap_cnt  <= GAP_W'(1);
        mrs_seen <= mrs_seen + 3'd1;
      end else if (gap_cnt < GAP_W'(MRD)) begin
        gap_cnt <= gap_cnt + GAP_W'(1);
      end
      if (is_zq)
        zq_seen <= 1'b1;
    end
    if (rst || !dram_rst_n)
      low_cnt <= '0;
    else if (!dram_cke && low_cnt < LOW_W'(CKEL))
      low_cnt <= low_cnt + LOW_W'(1);
  end

  always_comb begin
    case (mrs_seen)
      3'd0:    exp_ba = BA_W'(2);
      3'd1:    exp_ba = BA_W'(3);
      3'd2:    exp_ba = BA_W'(1);
      default: exp_ba = BA_W'(0);
    endcase
  end

  a_r11_cmd_only_when_up: assert property (@(posedge clk) disable iff (rst)
    !is_nop |-> (dram_cke && dram_rst_n));

  a_r9_single_cycle_cmd: assert property (@(posedge clk) disable iff (rst)
    !is_nop |=> is_nop);

  a_r3_warm_entry: assert property (@(posedge clk) disable iff (rst)
    warm_req |=> (!dram_rst_n && !dram_cke && !init_done));

  a_r7_mrs_spacing: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> (gap_cnt >= GAP_W'(MRD)));

  a_r6_mrs_order: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> (dram_ba == exp_ba && mrs_seen < 3'd4));

  a_r10_done_after_zq: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (zq_seen && mrs_seen == 3'd4));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (init_done && !warm_req) |=> init_done);

  a_r4_cke_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_cke) |-> (low_cnt >= LOW_W'(CKEL)));

endmodule

bind ddr3_init_seq ddr3_init_seq_chk #(
  .BA_W (BA_W),
  .MRD  (T_MRD),
  .CKEL (CKEL_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .warm_req   (warm_req),
  .dram_rst_n (dram_rst_n),
  .dram_cke   (dram_cke),
  .dram_cs_n  (dram_cs_n),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_ba    (dram_ba),
  .init_done  (init_done)
);

// File: tb/ddr3_init_seq_tb.sv
`timescale 1ns/1ps
module ddr3_init_seq_tb;

  localparam int AW = 14;
  localparam int BW = 3;
  localparam int P_COLD = 20, P_WARM = 3, P_PRE = 5, P_CKEW = 12, P_C10 = 2;
  localparam int P_XS = 3, P_MRD = 4, P_MOD = 12, P_DLLK = 16, P_ZQI = 10;
  // expected folded intervals
  localparam int E_WARM = (P_WARM > P_PRE) ? P_WARM : P_PRE;
  localparam int E_STB  = (P_C10 > 5) ? P_C10 : 5;
  localparam int E_CKEL = (P_CKEW > E_STB) ? P_CKEW : E_STB;
  localparam int E_XPR  = (P_XS > 5) ? P_XS : 5;
  localparam int E_ZQW  = (P_DLLK > P_ZQI) ? P_DLLK : P_ZQI;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic warm_req = 1'b0;
  logic [AW-1:0] mr0 = '0, mr1 = '0, mr2 = '0, mr3 = '0;
  logic dram_rst_n, dram_cke, dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n, init_done;
  logic [BW-1:0] dram_ba;
  logic [AW-1:0] dram_addr;

  always #4 clk = ~clk;

  ddr3_init_seq #(
    .T_RST_COLD(P_COLD), .T_RST_WARM(P_WARM), .T_CKE_PRE(P_PRE), .T_CKE_WAIT(P_CKEW),
    .T_CLK_10NS(P_C10), .T_XS(P_XS), .T_MRD(P_MRD), .T_MOD(P_MOD),
    .T_DLLK(P_DLLK), .T_ZQINIT(P_ZQI), .ADDR_W(AW), .BA_W(BW)
  ) u_dut (
    .clk(clk), .rst(rst), .warm_req(warm_req),
    .mr0(mr0), .mr1(mr1), .mr2(mr2), .mr3(mr3),
    .dram_rst_n(dram_rst_n), .dram_cke(dram_cke), .dram_cs_n(dram_cs_n),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_ba(dram_ba), .dram_addr(dram_addr), .init_done(init_done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk_eq(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // event log, filled at falling edges
  int t_rstn, t_cke, t_zq, t_done, n_mrs, n_zq, n_bad;
  int t_mrs[4];
  int ba_mrs[4];
  int a_mrs[4];
  int a_zq, ba_zq;
  logic p_rstn = 1'b0, p_cke = 1'b0, p_done = 1'b0;

  task automatic clear_log();
    t_rstn = -1; t_cke = -1; t_zq = -1; t_done = -1;
    n_mrs = 0; n_zq = 0; n_bad = 0; a_zq = -1; ba_zq = -1;
    for (int i = 0; i < 4; i++) begin
      t_mrs[i] = -1; ba_mrs[i] = -1; a_mrs[i] = -1;
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] pins;
    pins = {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n};
    case (pins)
      4'b0111: ;
      4'b0000: begin
        if (n_mrs < 4) begin
          t_mrs[n_mrs] = cyc; ba_mrs[n_mrs] = int'(dram_ba); a_mrs[n_mrs] = int'(dram_addr);
        end
        n_mrs++;
      end
      4'b0110: begin
        t_zq = cyc; a_zq = int'(dram_addr); ba_zq = int'(dram_ba); n_zq++;
      end
      default: n_bad++;
    endcase
    if (pins != 4'b0111 && (!dram_cke || !dram_rst_n)) n_bad++;
    if (dram_rst_n && !p_rstn) t_rstn = cyc;
    if (dram_cke && !p_cke) t_cke = cyc;
    if (init_done && !p_done) t_done = cyc;
    p_rstn = dram_rst_n; p_cke = dram_cke; p_done = init_done;
  end

  task automatic set_modes(input int k);
    mr0 = AW'(k * 7 + 5);
    mr1 = AW'(k * 13 + 1000);
    mr2 = AW'(k * 3 + 2222);
    mr3 = AW'(k * 11 + 4444);
  endtask

  // full timeline check; e = last edge that sampled the reset input, h = expected hold
  task automatic check_seq(input int e, input int h, input string rtag);
    int wait_n;
    wait_n = 0;
    while (!init_done && wait_n < 300) begin
      @(negedge clk);
      wait_n++;
    end
    repeat (10) @(negedge clk);
    chk_eq({rtag, " reset hold"}, t_rstn, e + h);
    chk_eq("R4 cke after reset release", t_cke, t_rstn + E_CKEL);
    chk_eq("R5 first MRS after cke", t_mrs[0], t_cke + E_XPR);
    chk_eq("R6 mrs count", n_mrs, 4);
    chk_eq("R6 ba slot0", ba_mrs[0], 2);
    chk_eq("R6 ba slot1", ba_mrs[1], 3);
    chk_eq("R6 ba slot2", ba_mrs[2], 1);
    chk_eq("R6 ba slot3", ba_mrs[3], 0);
    chk_eq("R6 value mr2", a_mrs[0], int'(mr2));
    chk_eq("R6 value mr3", a_mrs[1], int'(mr3));
    chk_eq("R6 value mr1", a_mrs[2], int'(mr1));
    chk_eq("R6 value mr0", a_mrs[3], int'(mr0));
    for (int i = 1; i < 4; i++)
      chk_eq("R7 mrs spacing", t_mrs[i] - t_mrs[i-1], P_MRD);
    chk_eq("R8 zq after MR0", t_zq, t_mrs[3] + P_MOD);
    chk_eq("R8 zq address", a_zq, 1 << 10);
    chk_eq("R8 zq bank", ba_zq, 0);
    chk_eq("R9 illegal or early commands", n_bad, 0);
    chk_eq("R9 zq count", n_zq, 1);
    chk_eq("R10 done after zq", t_done, t_zq + E_ZQW);
    chk_eq("R10 done held", int'(init_done), 1);
  endtask

  task automatic cold_reset(input int cycles);
    rst = 1'b1;
    repeat (cycles) @(posedge clk);
    #2 rst = 1'b0;
  endtask

  initial begin
    int e;
    clear_log();
    set_modes(0);
    repeat (3) @(posedge clk);
    #2;
    // R1: state during reset
    chk_eq("R1 rst_n low", int'(dram_rst_n), 0);
    chk_eq("R1 cke low", int'(dram_cke), 0);
    chk_eq("R1 done low", int'(init_done), 0);
    chk_eq("R1 NOP pins", int'({dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n}), 4'b0111);
    chk_eq("R1 ba zero", int'(dram_ba), 0);
    chk_eq("R1 addr zero", int'(dram_addr), 0);
    rst = 1'b0;
    e = cyc;
    clear_log();
    check_seq(e, P_COLD, "R2");

    // sweep warm request over every offset of a full sequence
    for (int k = 0; k < 86; k++) begin
      @(posedge clk);
      #2;
      set_modes(k + 1);
      cold_reset(2);
      repeat (k) @(posedge clk);
      #2 warm_req = 1'b1;
      @(posedge clk);
      #2 warm_req = 1'b0;
      e = cyc;
      clear_log();
      @(negedge clk);
      chk_eq("R3 entry rst_n", int'(dram_rst_n), 0);
      chk_eq("R3 entry cke", int'(dram_cke), 0);
      chk_eq("R3 entry done", int'(init_done), 0);
      check_seq(e, E_WARM, "R3");
    end

    // warm request held for several cycles after completion
    @(posedge clk);
    #2 set_modes(200);
    warm_req = 1'b1;
    repeat (3) @(posedge clk);
    #2 warm_req = 1'b0;
    e = cyc;
    clear_log();
    check_seq(e, E_WARM, "R3 held");

    // cold reset applied in the middle of a warm sequence
    @(posedge clk);
    #2 warm_req = 1'b1;
    @(posedge clk);
    #2 warm_req = 1'b0;
    repeat (30) @(posedge clk);
    #2;
    cold_reset(4);
    e = cyc;
    clear_log();
    check_seq(e, P_COLD, "R2 mid-run");

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule